// File: doc/BRIEF.md
# Register field update logic

This block holds one field of a generated control and status register bank. The field is 1 to 32 bits wide and sits at a byte-aligned offset inside the bus word. The field can be changed from two sides. The software side provides a decoded write strobe, write data, per-byte enables, an optional write gate and a read strobe. The hardware side provides new data and, optionally, an enable whose polarity is chosen by a parameter. The present value of the field is always visible on an output, so surrounding logic can use it directly.

Each clock cycle, the next value comes from an ordered chain of update branches. By default the chain checks the software write first, then the hardware write, then read-to-clear, then single-pulse. When none of them applies, the field holds its value. A precedence parameter moves the hardware write ahead of the software write. A hardware write without an enable loads the field every cycle, so every branch below it is dead.

A normal software write works lane by lane: only the bytes of the field whose enable is set take new data. In write-1-to-clear and write-1-to-set modes, the whole field changes together, and the byte enables are not used.

Top module: `regfield_cell`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `field_q` loads `RESET_VAL` at that edge.
- R2: In normal write mode, a taken software write updates field bit b from `sw_wdata[LSB+b]` only when `sw_be[(LSB+b)/8]` is 1. Bus byte lane k is `sw_wdata[8k+7:8k]` and is enabled by `sw_be[k]`. All other field bits keep their value.
- R3: A software write is taken only when `sw_wr` is 1 and the gate allows it. `SW_GATE`=GATE_NONE always allows it, GATE_HIGH needs `sw_wgate`=1, and GATE_LOW needs `sw_wgate`=0. A gated-off write has no effect, and the lower branches are evaluated as if no write had been made.
- R4: With `HW_MODE`=HW_ENABLED, a hardware write is taken when `hw_we` equals 1, or 0 if `HW_EN_LOW` is set. A taken hardware write loads `hw_wdata` into the field on the next edge.
- R5: With `HW_MODE`=HW_UNCOND, the field loads `hw_wdata` on every edge in which no software write of higher priority is taken. Read-to-clear and single-pulse never take effect.
- R6: When a software write and a hardware write are both taken in the same cycle, the software write wins if `HW_PRIO`=0 and the hardware write wins if `HW_PRIO`=1.
- R7: In write-1-to-clear mode, a taken software write clears each field bit whose write-data bit is 1, ignoring `sw_be`.
- R8: In write-1-to-set mode, a taken software write sets each field bit whose write-data bit is 1, ignoring `sw_be`.
- R9: With `RD_CLR`=1, a cycle with `sw_rd`=1 and no taken write shows the current value on `field_q` during that cycle and loads zero on the next edge.
- R10: With `SINGLE_PULSE`=1, a cycle with no taken write (and, if enabled, no read-to-clear) loads zero. A 1 written by software is therefore held for exactly one cycle.
- R11: A taken normal-mode software write whose spanned byte enables are all 0 leaves the field unchanged and still blocks the hardware, read-to-clear and single-pulse branches below it.
- R12: When no branch applies, the field keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr | input | 1 | Decoded software write strobe |
| sw_wdata | input | BUS_W | Software write data, whole bus word |
| sw_be | input | BUS_W/8 | Byte enables of the bus word |
| sw_wgate | input | 1 | Software write gate (polarity from SW_GATE) |
| sw_rd | input | 1 | Decoded software read strobe |
| hw_wdata | input | FIELD_W | Hardware write data |
| hw_we | input | 1 | Hardware write enable (polarity from HW_EN_LOW) |
| field_q | output | FIELD_W | Current field value |

## Verification
The collision that matters is a software write and a hardware write taken in the same cycle. A close second is read-to-clear, or the single-pulse return, arriving together with either write. The bench drives seven instances that differ in mode, gating and precedence from one shared pseudo-random stream. In that stream every strobe and enable is active about half the time, so collisions, gated-off writes and writes with no lane enabled all occur often. A bench-side model of the branch chain predicts each next value, and the branch that decided that value selects the requirement the check reports.

// File: rtl/regfield_pkg.sv
package regfield_pkg;

   typedef enum logic [1:0] {WM_NORMAL, WM_W1C, WM_W1S} wr_mode_e;
   typedef enum logic [1:0] {HW_NONE, HW_UNCOND, HW_ENABLED} hw_mode_e;
   typedef enum logic [1:0] {GATE_NONE, GATE_HIGH, GATE_LOW} gate_mode_e;
   typedef enum logic [2:0] {SEL_HOLD, SEL_SW, SEL_HW, SEL_RDCLR, SEL_PULSE} upd_sel_e;

   function automatic int lane_of(input int bitpos);
      return bitpos / 8;
   endfunction

endpackage

// File: rtl/regfield_sw_path.sv
module regfield_sw_path
   import regfield_pkg::*;
#(
   parameter int         BUS_W   = 32,
   parameter int         FIELD_W = 12,
   parameter int         LSB     = 8,
   parameter wr_mode_e   WR_MODE = WM_NORMAL,
   parameter gate_mode_e SW_GATE = GATE_NONE
) (
   input  logic [FIELD_W-1:0] cur,
   input  logic               sw_wr,
   input  logic               sw_wgate,
   input  logic [BUS_W-1:0]   sw_wdata,
   input  logic [BUS_W/8-1:0] sw_be,
   output logic               sw_hit,
   output logic [FIELD_W-1:0] sw_val,
   output logic [FIELD_W-1:0] lane_mask
);
   localparam int LO_LANE = lane_of(LSB);
   localparam int HI_LANE = lane_of(LSB + FIELD_W - 1);
   localparam int N_LANES = HI_LANE - LO_LANE + 1;

   logic [FIELD_W-1:0] fdata;
   logic               gate_ok;
   logic               unused_sw;

   assign fdata     = sw_wdata[LSB +: FIELD_W];
   assign unused_sw = ^{sw_wdata, sw_be, sw_wgate};

   // write gate polarity
   if (SW_GATE == GATE_HIGH) begin : g_gate_hi
      assign gate_ok = sw_wgate;
   end else if (SW_GATE == GATE_LOW) begin : g_gate_lo
      assign gate_ok = ~sw_wgate;
   end else begin : g_gate_none
      assign gate_ok = 1'b1;
   end

   assign sw_hit = sw_wr & gate_ok;

   if (WR_MODE == WM_W1C) begin : g_w1c
      assign sw_val    = cur & ~fdata;
      assign lane_mask = '1;
   end else if (WR_MODE == WM_W1S) begin : g_w1s
      assign sw_val    = cur | fdata;
      assign lane_mask = '1;
   end else begin : g_lanes
      for (genvar j = 0; j < N_LANES; j++) begin : g_lane
         localparam int LO = 8 * j;
         localparam int HI = (j == N_LANES - 1) ? FIELD_W - 1 : 8 * j + 7;
         logic en;
         assign en                = sw_be[LO_LANE + j];
         assign sw_val[HI:LO]     = en ? fdata[HI:LO] : cur[HI:LO];
         assign lane_mask[HI:LO]  = {(HI - LO + 1){en}};
      end
   end

endmodule

// File: rtl/regfield_hw_path.sv
module regfield_hw_path
   import regfield_pkg::*;
#(
   parameter hw_mode_e HW_MODE   = HW_ENABLED,
   parameter bit       HW_EN_LOW = 1'b0
) (
   input  logic hw_we,
   output logic hw_hit
);
   logic unused_hw;
   assign unused_hw = hw_we;

   if (HW_MODE == HW_UNCOND) begin : g_uncond
      assign hw_hit = 1'b1;
   end else if (HW_MODE == HW_ENABLED) begin : g_enabled
      // an active-low enable is inverted before use
      assign hw_hit = hw_we ^ HW_EN_LOW;
   end else begin : g_none
      assign hw_hit = 1'b0;
   end

endmodule

// File: rtl/regfield_prio.sv
module regfield_prio
   import regfield_pkg::*;
#(
   parameter bit HW_PRIO      = 1'b0,
   parameter bit RD_CLR       = 1'b0,
   parameter bit SINGLE_PULSE = 1'b0
) (
   input  logic     sw_hit,
   input  logic     hw_hit,
   input  logic     sw_rd,
   output upd_sel_e sel
);
   logic     first_hit, second_hit;
   upd_sel_e first_sel, second_sel;

   if (HW_PRIO) begin : g_hw_first
      assign first_hit  = hw_hit;
      assign first_sel  = SEL_HW;
      assign second_hit = sw_hit;
      assign second_sel = SEL_SW;
   end else begin : g_sw_first
      assign first_hit  = sw_hit;
      assign first_sel  = SEL_SW;
      assign second_hit = hw_hit;
      assign second_sel = SEL_HW;
   end

   always_comb begin
      if (first_hit)              sel = first_sel;
      else if (second_hit)        sel = second_sel;
      else if (RD_CLR && sw_rd)   sel = SEL_RDCLR;
      else if (SINGLE_PULSE)      sel = SEL_PULSE;
      else                        sel = SEL_HOLD;
   end

endmodule

// File: rtl/regfield_cell.sv
module regfield_cell
   import regfield_pkg::*;
#(
   parameter int                 BUS_W        = 32,
   parameter int                 FIELD_W      = 12,
   parameter int                 LSB          = 8,
   parameter logic [FIELD_W-1:0] RESET_VAL    = '0,
   parameter wr_mode_e           WR_MODE      = WM_NORMAL,
   parameter hw_mode_e           HW_MODE      = HW_ENABLED,
   parameter bit                 HW_EN_LOW    = 1'b0,
   parameter gate_mode_e         SW_GATE      = GATE_NONE,
   parameter bit                 HW_PRIO      = 1'b0,
   parameter bit                 RD_CLR       = 1'b0,
   parameter bit                 SINGLE_PULSE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_wr,
   input  logic [BUS_W-1:0]   sw_wdata,
   input  logic [BUS_W/8-1:0] sw_be,
   input  logic               sw_wgate,
   input  logic               sw_rd,
   input  logic [FIELD_W-1:0] hw_wdata,
   input  logic               hw_we,
   output logic [FIELD_W-1:0] field_q
);
   // elaboration-time parameter checks
   if (FIELD_W < 1 || FIELD_W > 32) begin : g_bad_width
      $error("regfield_cell: FIELD_W must lie in 1..32");
   end
   if (LSB % 8 != 0) begin : g_bad_align
      $error("regfield_cell: LSB must be byte aligned");
   end
   if (LSB + FIELD_W > BUS_W || BUS_W % 8 != 0) begin : g_bad_fit
      $error("regfield_cell: field must fit a byte-multiple bus word");
   end

   logic               sw_hit, hw_hit;
   logic [FIELD_W-1:0] sw_val, lane_mask, nxt;
   upd_sel_e           sel;

   regfield_sw_path #(
      .BUS_W(BUS_W), .FIELD_W(FIELD_W), .LSB(LSB),
      .WR_MODE(WR_MODE), .SW_GATE(SW_GATE)
   ) u_sw (
      .cur(field_q), .sw_wr(sw_wr), .sw_wgate(sw_wgate), .sw_wdata(sw_wdata),
      .sw_be(sw_be), .sw_hit(sw_hit), .sw_val(sw_val), .lane_mask(lane_mask)
   );

   regfield_hw_path #(.HW_MODE(HW_MODE), .HW_EN_LOW(HW_EN_LOW)) u_hw (
      .hw_we(hw_we), .hw_hit(hw_hit)
   );

   regfield_prio #(
      .HW_PRIO(HW_PRIO), .RD_CLR(RD_CLR), .SINGLE_PULSE(SINGLE_PULSE)
   ) u_prio (
      .sw_hit(sw_hit), .hw_hit(hw_hit), .sw_rd(sw_rd), .sel(sel)
   );

   always_comb begin
      case (sel)
         SEL_SW:              nxt = sw_val;
         SEL_HW:              nxt = hw_wdata;
         SEL_RDCLR, SEL_PULSE: nxt = '0;
         default:             nxt = field_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) field_q <= RESET_VAL;
      else        field_q <= nxt;
   end

   // ---------------- assertions ----------------
   p_reset_val_r1: assert property (@(posedge clk) !rst_n |=> field_q == RESET_VAL);

   p_lane_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_SW && WR_MODE == WM_NORMAL)
      |=> ((field_q ^ $past(field_q)) & ~$past(lane_mask)) == '0);

   p_gate_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && !sw_hit) |-> sel != SEL_SW);

   p_hw_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sel == SEL_HW |=> field_q == $past(hw_wdata));

   p_uncond_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      HW_MODE == HW_UNCOND |-> (sel == SEL_SW || sel == SEL_HW));

   p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_hit && hw_hit) |-> sel == (HW_PRIO ? SEL_HW : SEL_SW));

   p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_SW && WR_MODE == WM_W1C)
      |=> (field_q & $past(sw_wdata[LSB +: FIELD_W])) == '0);

   p_w1s_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_SW && WR_MODE == WM_W1S)
      |=> (field_q & $past(sw_wdata[LSB +: FIELD_W])) == $past(sw_wdata[LSB +: FIELD_W]));

   p_rdclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sel == SEL_RDCLR |=> field_q == '0);

   p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sel == SEL_PULSE |=> field_q == '0);

   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      sel == SEL_HOLD |=> $stable(field_q));

endmodule

// File: tb/regfield_cell_tb.sv
module regfield_cell_tb;
   import regfield_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int N_DUT      = 7;
   localparam int N_CYC      = 4000;

   typedef struct packed {
      logic [5:0]  w;
      logic [5:0]  lsb;
      logic [1:0]  mode;   // 0 normal, 1 w1c, 2 w1s
      logic [1:0]  hwm;    // 0 none, 1 unconditional, 2 enabled
      logic        hwl;
      logic [1:0]  gate;   // 0 none, 1 high, 2 low
      logic        hwp;
      logic        rdc;
      logic        sp;
      logic [31:0] rst;
   } cfg_t;

   function automatic cfg_t cfg(input int i);
      case (i)
         0: return '{12, 8, 0, 2, 1, 1, 0, 1, 0, 32'hA5C};
         1: return '{12, 8, 0, 2, 0, 0, 1, 1, 0, 32'h3C1};
         2: return '{8, 16, 1, 2, 0, 2, 0, 0, 0, 32'hFF};
         3: return '{5, 0, 2, 0, 0, 0, 0, 1, 0, 32'h0A};
         4: return '{1, 24, 0, 0, 0, 0, 0, 0, 1, 32'h0};
         5: return '{8, 0, 0, 1, 0, 0, 1, 1, 1, 32'h81};
         default: return '{8, 8, 0, 1, 0, 1, 0, 1, 1, 32'h42};
      endcase
   endfunction

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_wr = 1'b0, sw_wgate = 1'b0, sw_rd = 1'b0, hw_we = 1'b0;
   logic [31:0] sw_wdata = '0, hw_wdata = '0;
   logic [3:0]  sw_be = '0;

   logic [11:0] q0, q1;
   logic [7:0]  q2, q5, q6;
   logic [4:0]  q3;
   logic [0:0]  q4;
   logic [31:0] act [N_DUT];

   int          n_chk = 0, n_fail = 0;
   logic        done = 1'b0;
   logic [31:0] lfsr = 32'h1234_5678;

   always #(CLK_PERIOD / 2) clk = ~clk;

   regfield_cell #(.FIELD_W(12), .LSB(8), .RESET_VAL(12'hA5C), .WR_MODE(WM_NORMAL),
      .HW_MODE(HW_ENABLED), .HW_EN_LOW(1'b1), .SW_GATE(GATE_HIGH), .HW_PRIO(1'b0),
      .RD_CLR(1'b1), .SINGLE_PULSE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_be(sw_be),
      .sw_wgate(sw_wgate), .sw_rd(sw_rd), .hw_wdata(hw_wdata[11:0]), .hw_we(hw_we), .field_q(q0));

   regfield_cell #(.FIELD_W(12), .LSB(8), .RESET_VAL(12'h3C1), .WR_MODE(WM_NORMAL),
      .HW_MODE(HW_ENABLED), .HW_EN_LOW(1'b0), .SW_GATE(GATE_NONE), .HW_PRIO(1'b1),
      .RD_CLR(1'b1), .SINGLE_PULSE(1'b0)) u_dut_hwp (
      .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_be(sw_be),
      .sw_wgate(sw_wgate), .sw_rd(sw_rd), .hw_wdata(hw_wdata[11:0]), .hw_we(hw_we), .field_q(q1));

   regfield_cell #(.FIELD_W(8), .LSB(16), .RESET_VAL(8'hFF), .WR_MODE(WM_W1C),
      .HW_MODE(HW_ENABLED), .HW_EN_LOW(1'b0), .SW_GATE(GATE_LOW), .HW_PRIO(1'b0),
      .RD_CLR(1'b0), .SINGLE_PULSE(1'b0)) u_dut_w1c (
      .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_be(sw_be),
      .sw_wgate(sw_wgate), .sw_rd(sw_rd), .hw_wdata(hw_wdata[7:0]), .hw_we(hw_we), .field_q(q2));

   regfield_cell #(.FIELD_W(5), .LSB(0), .RESET_VAL(5'h0A), .WR_MODE(WM_W1S),
      .HW_MODE(HW_NONE), .HW_EN_LOW(1'b0), .SW_GATE(GATE_NONE), .HW_PRIO(1'b0),
      .RD_CLR(1'b1), .SINGLE_PULSE(1'b0)) u_dut_w1s (
      .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_be(sw_be),
      .sw_wgate(sw_wgate), .sw_rd(sw_rd), .hw_wdata(hw_wdata[4:0]), .hw_we(hw_we), .field_q(q3));

   regfield_cell #(.FIELD_W(1), .LSB(24), .RESET_VAL(1'b0), .WR_MODE(WM_NORMAL),
      .HW_MODE(HW_NONE), .HW_EN_LOW(1'b0), .SW_GATE(GATE_NONE), .HW_PRIO(1'b0),
      .RD_CLR(1'b0), .SINGLE_PULSE(1'b1)) u_dut_sp (
      .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_be(sw_be),
      .sw_wgate(sw_wgate), .sw_rd(sw_rd), .hw_wdata(hw_wdata[0:0]), .hw_we(hw_we), .field_q(q4));

   regfield_cell #(.FIELD_W(8), .LSB(0), .RESET_VAL(8'h81), .WR_MODE(WM_NORMAL),
      .HW_MODE(HW_UNCOND), .HW_EN_LOW(1'b0), .SW_GATE(GATE_NONE), .HW_PRIO(1'b1),
      .RD_CLR(1'b1), .SINGLE_PULSE(1'b1)) u_dut_unh (
      .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_be(sw_be),
      .sw_wgate(sw_wgate), .sw_rd(sw_rd), .hw_wdata(hw_wdata[7:0]), .hw_we(hw_we), .field_q(q5));

   regfield_cell #(.FIELD_W(8), .LSB(8), .RESET_VAL(8'h42), .WR_MODE(WM_NORMAL),
      .HW_MODE(HW_UNCOND), .HW_EN_LOW(1'b0), .SW_GATE(GATE_HIGH), .HW_PRIO(1'b0),
      .RD_CLR(1'b1), .SINGLE_PULSE(1'b1)) u_dut_uns (
      .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_be(sw_be),
      .sw_wgate(sw_wgate), .sw_rd(sw_rd), .hw_wdata(hw_wdata[7:0]), .hw_we(hw_we), .field_q(q6));

   assign act[0] = 32'(q0);
   assign act[1] = 32'(q1);
   assign act[2] = 32'(q2);
   assign act[3] = 32'(q3);
   assign act[4] = 32'(q4);
   assign act[5] = 32'(q5);
   assign act[6] = 32'(q6);

   function automatic logic [31:0] rnd();
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      return lfsr;
   endfunction

   // requirement-level model of the update chain; tag names the deciding rule
   task automatic model(input cfg_t c, input logic [31:0] cur,
                        output logic [31:0] nxt, output string tag);
      logic [31:0] mask, fd, swv;
      logic        gate_ok, swh, hwh, anyl;
      mask = 32'hFFFF_FFFF >> (32 - int'(c.w));
      fd   = (sw_wdata >> c.lsb) & mask;
      gate_ok = (c.gate == 0) ? 1'b1 : (c.gate == 1) ? sw_wgate : !sw_wgate;
      swh  = sw_wr && gate_ok;
      hwh  = (c.hwm == 1) ? 1'b1 : (c.hwm == 2) ? (hw_we ^ c.hwl) : 1'b0;
      anyl = 1'b0;
      swv  = cur;
      if (c.mode == 1)      swv = cur & ~fd;
      else if (c.mode == 2) swv = cur | fd;
      else begin
         for (int b = 0; b < int'(c.w); b++) begin
            if (sw_be[(int'(c.lsb) + b) / 8]) begin
               swv[b] = fd[b];
               anyl   = 1'b1;
            end
         end
      end
      if (c.hwp && hwh) begin
         nxt = hw_wdata & mask;
         tag = swh ? "R6" : (c.hwm == 1) ? "R5" : "R4";
      end else if (swh) begin
         nxt = swv;
         tag = hwh ? "R6" : (c.mode == 1) ? "R7" : (c.mode == 2) ? "R8" : anyl ? "R2" : "R11";
      end else if (hwh) begin
         nxt = hw_wdata & mask;
         tag = (c.hwm == 1) ? "R5" : "R4";
      end else if (c.rdc && sw_rd) begin
         nxt = '0;
         tag = "R9";
      end else if (c.sp) begin
         nxt = '0;
         tag = "R10";
      end else begin
         nxt = cur;
         tag = sw_wr ? "R3" : "R12";
      end
   endtask

   task automatic check(input int i, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act[i] !== exp) begin
         n_fail++;
         $display("FAIL %s dut%0d: actual %h expected %h", tag, i, act[i], exp);
      end
   endtask

   task automatic drive_random();
      logic [31:0] r;
      r        = rnd();
      sw_wr    = r[0];
      sw_wgate = r[1];
      sw_rd    = r[2];
      hw_we    = r[3];
      sw_be    = r[7:4];
      sw_wdata = rnd();
      hw_wdata = rnd();
   endtask

   initial begin
      logic [31:0] exp_q [N_DUT];
      logic [31:0] nxt_q [N_DUT];
      string       tag_q [N_DUT];
      drive_random();
      repeat (2) @(negedge clk);
      // R1: reset state at the ports
      for (int i = 0; i < N_DUT; i++) begin
         exp_q[i] = cfg(i).rst;
         check(i, exp_q[i], "R1");
      end
      rst_n = 1'b1;
      for (int cyc = 0; cyc < N_CYC; cyc++) begin
         drive_random();
         if (cyc == N_CYC / 2) begin
            rst_n = 1'b0;          // R1: reset during traffic
            for (int i = 0; i < N_DUT; i++) begin
               nxt_q[i] = cfg(i).rst;
               tag_q[i] = "R1";
            end
         end else begin
            rst_n = 1'b1;
            for (int i = 0; i < N_DUT; i++) model(cfg(i), exp_q[i], nxt_q[i], tag_q[i]);
         end
         @(negedge clk);
         for (int i = 0; i < N_DUT; i++) begin
            check(i, nxt_q[i], tag_q[i]);
            exp_q[i] = nxt_q[i];
         end
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (N_CYC + 1000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule